// File: doc/BRIEF.md
# Flash Buffered Block-Write Engine

This block is the buffered-program path of a parallel NOR-style flash command interface. A host drives single-cycle bus writes. Each write carries a byte address, a 32-bit data word and a width code. A block-write command is followed by a word count and then by a run of data writes. The data writes land in a shadow buffer, never in storage directly. When the count is taken, the shadow buffer covers one aligned write block and is preloaded with that block's current storage contents. A clean confirm then copies the whole buffer back, one 32-bit word per cycle. Any other ending throws the buffer away. Because of this, storage never holds a partly updated block.

The block holds the storage array, with a combinational read port, and a status byte. Bit 7 of the status byte is ready and bit 4 is program error. An input puts the device in read-only mode. Outside a block write, a single-word program command writes the next bus write straight to storage.

Top module: `flash_blkwr_engine`

## Requirements
- R1: After synchronous reset, status reads 0x80, busy is low, no buffer is active, every storage byte is zero and the engine decodes commands (read-array mode).
- R2: In read-array mode, a write whose low data byte is 0x40 or 0x10 arms a single program. The next write stores its bytes directly at the addressed location. The width code on wr_size selects the byte count: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. With the default lane order, data byte k goes to address+k, and rd_data returns the byte at rd_addr+k in byte k.
- R3: Low byte 0xE8 in read-array mode opens a block write. The next write supplies count N (the full 32-bit data word). Exactly N+1 further writes are then treated as data, and after that the engine waits for a confirm.
- R4: When the count write is taken, the buffer base is that write's address with its low log2(block size) bits cleared, and the buffer is filled from storage for that block. After a commit, bytes not written during the block write keep their earlier values.
- R5: A data write that starts below the base or ends beyond base+block size sets status bit 4 and changes nothing.
- R6: When ro_mode is high, block data writes and direct program writes set status bit 4 and store nothing.
- R7: Storage does not change between the block-write command and the end of the confirm write.
- R8: A confirm write with low byte 0xD0 while status bit 4 is clear copies the buffer into storage. busy is high for block size/4 cycles, during which status bit 7 reads 0. Afterwards status reads 0x80 with busy low.
- R9: In the confirm phase, any other value, or 0xD0 while status bit 4 is set, discards the buffer, leaves storage unchanged and returns to read-array mode.
- R10: Low byte 0x50 in read-array mode clears status bits 6:0. Low byte 0xFF returns to read-array mode and, in the confirm phase, discards the buffer. Error bit 4 never clears on its own.
- R11: Bus writes made while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ro_mode | input | 1 | Read-only mode: program and block data writes are refused |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Command byte (low 8 bits), count or data |
| wr_size | input | 2 | Width code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| rd_addr | input | ADDR_W | Byte address of the read port |
| rd_data | output | 32 | Four storage bytes starting at rd_addr |
| status | output | 8 | Bit 7 ready, bit 4 program error |
| busy | output | 1 | High while the buffer is being copied into storage |

## Verification
The bench sets up storage with known bytes and then runs block writes against that background. It checks that staged data cannot be read before the confirm, and that untouched bytes of the block survive the commit. If the preload were skipped, those bytes would be zeroed. The bench sends exactly three data writes whose low byte equals the confirm code, so an engine that takes one write too few or one too many starts the commit at the wrong time. Writes one byte below the base and writes that cross the block end are both rejected. A following 0xD0 must then discard the buffer instead of committing a partial block. The bench also checks that the commit lasts exactly eight cycles and that a command sent during it is ignored, so it cannot turn the next program data into a count.

// File: rtl/flash_bw_pkg.sv
package flash_bw_pkg;

    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = 8 * BUS_BYTES;

    localparam logic [7:0] CMD_BLOCK   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_PROG_A  = 8'h40;
    localparam logic [7:0] CMD_PROG_B  = 8'h10;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    localparam logic [7:0] STS_RESET   = 8'h80;
    localparam int         READY_BIT   = 7;
    localparam int         PERR_BIT    = 4;

    typedef enum logic [2:0] {
        PH_ARRAY   = 3'd0,
        PH_PROG    = 3'd1,
        PH_COUNT   = 3'd2,
        PH_DATA    = 3'd3,
        PH_CONFIRM = 3'd4,
        PH_COMMIT  = 3'd5
    } phase_e;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [2:0]       nbytes;
    } lane_wr_t;

    function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Byte that lands at address offset i of an access of n bytes.
    function automatic logic [7:0] lane_pick(input logic [BUS_W-1:0] d,
                                             input int i,
                                             input logic [2:0] n,
                                             input bit be);
        int k;
        if (i >= int'(n)) return 8'h00;
        k = be ? (int'(n) - 1 - i) : i;
        return d[8*k +: 8];
    endfunction

endpackage

// File: rtl/fbw_storage.sv
module fbw_storage
    import flash_bw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BLK_LG     = 5,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        dir_we,
    input  logic [ADDR_W-1:0]           dir_addr,
    input  lane_wr_t                    dir_wr,
    input  logic                        cmt_we,
    input  logic [ADDR_W-1:0]           cmt_addr,
    input  logic [BUS_W-1:0]            cmt_word,
    input  logic [ADDR_W-BLK_LG-1:0]    blk_sel,
    output logic [(8<<BLK_LG)-1:0]      blk_view,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BUS_W-1:0]            rd_data
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BLK_BYTES = 1 << BLK_LG;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DEPTH; d++) mem[d] <= 8'h00;
        end else begin
            if (dir_we) begin
                for (int i = 0; i < BUS_BYTES; i++) begin
                    if (i < int'(dir_wr.nbytes))
                        mem[dir_addr + ADDR_W'(i)] <=
                            lane_pick(dir_wr.data, i, dir_wr.nbytes, BIG_ENDIAN);
                end
            end
            if (cmt_we) begin
                for (int i = 0; i < BUS_BYTES; i++)
                    mem[cmt_addr + ADDR_W'(i)] <= cmt_word[8*i +: 8];
            end
        end
    end

    for (genvar j = 0; j < BLK_BYTES; j++) begin : g_view
        assign blk_view[8*j +: 8] = mem[{blk_sel, BLK_LG'(j)}];
    end

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_rd
        logic [ADDR_W-1:0] ra;
        assign ra = rd_addr + ADDR_W'(i);
        if (BIG_ENDIAN) begin : g_be
            assign rd_data[8*(BUS_BYTES-1-i) +: 8] = mem[ra];
        end else begin : g_le
            assign rd_data[8*i +: 8] = mem[ra];
        end
    end

endmodule

// File: rtl/fbw_stage_buf.sv
module fbw_stage_buf
    import flash_bw_pkg::*;
#(
    parameter int BLK_LG     = 5,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                    clk,
    input  logic                    load,
    input  logic [(8<<BLK_LG)-1:0]  load_bytes,
    input  logic                    we,
    input  logic [BLK_LG-1:0]       woff,
    input  lane_wr_t                wr,
    input  logic [BLK_LG-3:0]       word_idx,
    output logic [BUS_W-1:0]        word_out
);
    localparam int BLK_BYTES = 1 << BLK_LG;

    logic [7:0] shadow [BLK_BYTES];

    always_ff @(posedge clk) begin
        if (load) begin
            for (int j = 0; j < BLK_BYTES; j++)
                shadow[j] <= load_bytes[8*j +: 8];
        end else if (we) begin
            for (int i = 0; i < BUS_BYTES; i++) begin
                if (i < int'(wr.nbytes))
                    shadow[woff + BLK_LG'(i)] <= lane_pick(wr.data, i, wr.nbytes, BIG_ENDIAN);
            end
        end
    end

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_word
        assign word_out[8*i +: 8] = shadow[{word_idx, 2'(i)}];
    end

endmodule

// File: rtl/fbw_ctrl.sv
module fbw_ctrl
    import flash_bw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_LG = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BUS_W-1:0]         wr_data,
    input  logic [2:0]               nbytes,
    input  logic                     ro,
    output phase_e                   phase,
    output logic [7:0]               status,
    output logic                     busy,
    output logic                     buf_valid,
    output logic                     dir_we,
    output logic                     stage_load,
    output logic                     stage_we,
    output logic [BLK_LG-1:0]        stage_off,
    output logic [ADDR_W-BLK_LG-1:0] blk_sel,
    output logic                     cmt_we,
    output logic [ADDR_W-1:0]        cmt_addr,
    output logic [BLK_LG-3:0]        cmt_idx
);
    localparam int               BLK_BYTES = 1 << BLK_LG;
    localparam int               NWORDS    = BLK_BYTES / BUS_BYTES;
    localparam logic [BLK_LG-3:0] LAST_IDX = (BLK_LG-2)'(NWORDS - 1);

    phase_e              phase_q;
    logic [7:0]          stat_q;
    logic [BUS_W-1:0]    cnt_q;
    logic [ADDR_W-1:0]   base_q;
    logic [BLK_LG-3:0]   cidx_q;
    logic                valid_q;

    logic [7:0]          cmd;
    logic [ADDR_W:0]     end_req;
    logic [ADDR_W:0]     end_lim;
    logic                in_range;
    logic                accept;

    assign cmd      = wr_data[7:0];
    assign end_req  = {1'b0, wr_addr} + (ADDR_W+1)'(nbytes);
    assign end_lim  = {1'b0, base_q} + (ADDR_W+1)'(BLK_BYTES);
    assign in_range = (wr_addr >= base_q) && (end_req <= end_lim);
    assign accept   = valid_q && !ro && in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ARRAY;
            stat_q  <= STS_RESET;
            cnt_q   <= '0;
            base_q  <= '0;
            cidx_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_ARRAY: if (wr_en) begin
                    if (cmd == CMD_BLOCK) begin
                        phase_q           <= PH_COUNT;
                        stat_q[READY_BIT] <= 1'b1;
                    end else if (cmd == CMD_PROG_A || cmd == CMD_PROG_B) begin
                        phase_q <= PH_PROG;
                    end else if (cmd == CMD_CLEAR) begin
                        stat_q[6:0] <= '0;
                    end
                end
                PH_PROG: if (wr_en) begin
                    phase_q           <= PH_ARRAY;
                    stat_q[READY_BIT] <= 1'b1;
                    if (ro) stat_q[PERR_BIT] <= 1'b1;
                end
                PH_COUNT: if (wr_en) begin
                    cnt_q   <= wr_data;
                    base_q  <= {wr_addr[ADDR_W-1:BLK_LG], {BLK_LG{1'b0}}};
                    valid_q <= 1'b1;
                    phase_q <= PH_DATA;
                end
                PH_DATA: if (wr_en) begin
                    stat_q[READY_BIT] <= 1'b1;
                    if (!accept) stat_q[PERR_BIT] <= 1'b1;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == '0) phase_q <= PH_CONFIRM;
                end
                PH_CONFIRM: if (wr_en) begin
                    if (cmd == CMD_CONFIRM && !stat_q[PERR_BIT]) begin
                        phase_q <= PH_COMMIT;
                        cidx_q  <= '0;
                    end else begin
                        valid_q <= 1'b0;
                        phase_q <= PH_ARRAY;
                    end
                end
                PH_COMMIT: begin
                    cidx_q <= cidx_q + 1'b1;
                    if (cidx_q == LAST_IDX) begin
                        phase_q           <= PH_ARRAY;
                        valid_q           <= 1'b0;
                        stat_q[READY_BIT] <= 1'b1;
                    end
                end
                default: phase_q <= PH_ARRAY;
            endcase
        end
    end

    assign phase      = phase_q;
    assign busy       = (phase_q == PH_COMMIT);
    assign status     = {stat_q[7] & ~busy, stat_q[6:0]};
    assign buf_valid  = valid_q;
    assign dir_we     = (phase_q == PH_PROG) && wr_en && !ro;
    assign stage_load = (phase_q == PH_COUNT) && wr_en;
    assign stage_we   = (phase_q == PH_DATA) && wr_en && accept;
    assign stage_off  = wr_addr[BLK_LG-1:0];
    assign blk_sel    = wr_addr[ADDR_W-1:BLK_LG];
    assign cmt_we     = busy;
    assign cmt_idx    = cidx_q;
    assign cmt_addr   = {base_q[ADDR_W-1:BLK_LG], cidx_q, 2'b00};

endmodule

// File: rtl/flash_blkwr_engine.sv
module flash_blkwr_engine
    import flash_bw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BLK_LG     = 5,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ro_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        wr_size,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [7:0]        status,
    output logic              busy
);
    localparam int NWORDS_L = (1 << BLK_LG) / BUS_BYTES;

    lane_wr_t                  bus_wr;
    phase_e                    phase_w;
    logic                      buf_valid_w;
    logic                      dir_we_w;
    logic                      stage_load_w;
    logic                      stage_we_w;
    logic [BLK_LG-1:0]         stage_off_w;
    logic [ADDR_W-BLK_LG-1:0]  blk_sel_w;
    logic                      cmt_we_w;
    logic [ADDR_W-1:0]         cmt_addr_w;
    logic [BLK_LG-3:0]         cmt_idx_w;
    logic [BUS_W-1:0]          cmt_word_w;
    logic [(8<<BLK_LG)-1:0]    blk_view_w;

    assign bus_wr = '{data: wr_data, nbytes: size_to_bytes(wr_size)};

    fbw_ctrl #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .nbytes     (bus_wr.nbytes),
        .ro         (ro_mode),
        .phase      (phase_w),
        .status     (status),
        .busy       (busy),
        .buf_valid  (buf_valid_w),
        .dir_we     (dir_we_w),
        .stage_load (stage_load_w),
        .stage_we   (stage_we_w),
        .stage_off  (stage_off_w),
        .blk_sel    (blk_sel_w),
        .cmt_we     (cmt_we_w),
        .cmt_addr   (cmt_addr_w),
        .cmt_idx    (cmt_idx_w)
    );

    fbw_stage_buf #(.BLK_LG(BLK_LG), .BIG_ENDIAN(BIG_ENDIAN)) u_stage (
        .clk        (clk),
        .load       (stage_load_w),
        .load_bytes (blk_view_w),
        .we         (stage_we_w),
        .woff       (stage_off_w),
        .wr         (bus_wr),
        .word_idx   (cmt_idx_w),
        .word_out   (cmt_word_w)
    );

    fbw_storage #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG), .BIG_ENDIAN(BIG_ENDIAN)) u_store (
        .clk      (clk),
        .rst      (rst),
        .dir_we   (dir_we_w),
        .dir_addr (wr_addr),
        .dir_wr   (bus_wr),
        .cmt_we   (cmt_we_w),
        .cmt_addr (cmt_addr_w),
        .cmt_word (cmt_word_w),
        .blk_sel  (blk_sel_w),
        .blk_view (blk_view_w),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/flash_bw_checker.sv
module flash_bw_checker
    import flash_bw_pkg::*;
#(
    parameter int NWORDS = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_cmd,
    input logic       ro_mode,
    input logic       busy,
    input logic [7:0] status,
    input phase_e     phase,
    input logic       buf_valid,
    input logic       dir_we,
    input logic       stage_we,
    input logic       cmt_we
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    AST_DATA_HAS_BUFFER: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> buf_valid); // R3

    AST_RO_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        ro_mode |-> (!dir_we && !stage_we)); // R6

    AST_STAGING_STORAGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COUNT || phase == PH_DATA || phase == PH_CONFIRM) |-> !(dir_we || cmt_we)); // R7

    AST_COMMIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wr_en) && $past(wr_cmd) == CMD_CONFIRM && !$past(status[PERR_BIT]))); // R8

    AST_COMMIT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == 16'(NWORDS))); // R8

    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(status[PERR_BIT]) && !$past(wr_en)) |-> status[PERR_BIT]); // R10

endmodule

bind flash_blkwr_engine flash_bw_checker #(.NWORDS(NWORDS_L)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_cmd    (wr_data[7:0]),
    .ro_mode   (ro_mode),
    .busy      (busy),
    .status    (status),
    .phase     (phase_w),
    .buf_valid (buf_valid_w),
    .dir_we    (dir_we_w),
    .stage_we  (stage_we_w),
    .cmt_we    (cmt_we_w)
);

// File: tb/flash_blkwr_engine_tb_top.sv
module flash_blkwr_engine_tb_top;

    localparam int ADDR_W = 8;
    localparam int BLK_LG = 5;
    localparam int NWORDS = (1 << BLK_LG) / 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              ro_mode;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic [1:0]        wr_size;
    logic [ADDR_W-1:0] rd_addr;
    logic [31:0]       rd_data;
    logic [7:0]        status;
    logic              busy;

    always #2 clk = ~clk;

    flash_blkwr_engine #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG), .BIG_ENDIAN(1'b0)) dut_i (
        .clk(clk), .rst(rst), .ro_mode(ro_mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size(wr_size), .rd_addr(rd_addr), .rd_data(rd_data),
        .status(status), .busy(busy)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] m [256];

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [31:0] mword(input logic [7:0] a);
        return {m[a + 8'd3], m[a + 8'd2], m[a + 8'd1], m[a]};
    endfunction

    task automatic mput(input logic [7:0] a, input logic [31:0] d, input logic [1:0] code);
        int n;
        n = (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
        for (int i = 0; i < n; i++) m[a + 8'(i)] = d[8*i +: 8];
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] code);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        wr_size = code;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic prog(input logic [7:0] a, input logic [31:0] d, input logic [1:0] code);
        bus_wr(a, 32'h40, 2'd0);
        bus_wr(a, d, code);
        if (!ro_mode) mput(a, d, code);
    endtask

    // Driver side of the scoreboard: push the model's word and wait for the monitor.
    task automatic expect_word(input logic [7:0] a, input string tag);
        sb_q.push_back('{addr: a, exp: mword(a), tag: tag});
        wait (sb_q.size() == 0);
    endtask

    task automatic check_status(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(tag, {24'h0, status}, {24'h0, exp});
    endtask

    task automatic watch_commit(input string tag);
        int cyc;
        chk({tag, " busy high, ready low"}, {30'h0, busy, status[7]}, 32'h2);
        cyc = 0;
        while (busy) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " commit cycles"}, cyc, NWORDS);
    endtask

    // Monitor side of the scoreboard.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            rd_addr = sb_q[0].addr;
            #1;
            chk(sb_q[0].tag, rd_data, sb_q[0].exp);
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        rst = 1'b1; ro_mode = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; wr_size = '0; rd_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_status(8'h80, "R1 status after reset");
        chk("R1 busy after reset", {31'h0, busy}, 32'h0);
        expect_word(8'h00, "R1 storage zero");

        // R2 direct program, two-byte width, little-endian lanes
        prog(8'h05, 32'h11223344, 2'd1);
        expect_word(8'h04, "R2 direct two-byte program");
        prog(8'h20, 32'hA0A1A2A3, 2'd2);
        prog(8'h3C, 32'hB0B1B2B3, 2'd2);
        expect_word(8'h3C, "R2 direct four-byte program");
        check_status(8'h80, "R2 status after program");

        // R4/R7/R8 block write with preload and commit
        bus_wr(8'h20, 32'hE8, 2'd0);
        bus_wr(8'h2A, 32'd1, 2'd2);
        bus_wr(8'h24, 32'hDEADBEEF, 2'd2);
        expect_word(8'h24, "R7 staged data not in storage");
        bus_wr(8'h21, 32'h55, 2'd0);
        check_status(8'h80, "R8 status before confirm");
        bus_wr(8'h00, 32'hD0, 2'd0);
        watch_commit("R8");
        mput(8'h24, 32'hDEADBEEF, 2'd2);
        mput(8'h21, 32'h55, 2'd0);
        expect_word(8'h20, "R4 merged word at base");
        expect_word(8'h24, "R8 committed word");
        expect_word(8'h3C, "R4 preloaded tail kept");
        check_status(8'h80, "R8 status after commit");

        // R5/R9/R10 out-of-range writes, then confirm refused
        bus_wr(8'h40, 32'hE8, 2'd0);
        bus_wr(8'h4A, 32'd1, 2'd2);
        bus_wr(8'h3F, 32'h99, 2'd0);
        check_status(8'h90, "R5 write below base");
        bus_wr(8'h5E, 32'h12345678, 2'd2);
        bus_wr(8'h00, 32'hD0, 2'd0);
        chk("R9 no commit with error set", {31'h0, busy}, 32'h0);
        expect_word(8'h3C, "R5 below-base byte not stored");
        expect_word(8'h5C, "R9 storage untouched after refusal");
        check_status(8'h90, "R10 error bit sticky");
        bus_wr(8'h00, 32'h50, 2'd0);
        check_status(8'h80, "R10 clear status");

        // R9/R10 abort with 0xFF in confirm phase
        bus_wr(8'h60, 32'hE8, 2'd0);
        bus_wr(8'h60, 32'd0, 2'd2);
        bus_wr(8'h60, 32'h12345678, 2'd2);
        bus_wr(8'h00, 32'hFF, 2'd0);
        chk("R10 0xFF abort no busy", {31'h0, busy}, 32'h0);
        expect_word(8'h60, "R9 aborted block not stored");
        prog(8'h64, 32'h0BADF00D, 2'd2);
        expect_word(8'h64, "R9 read-array mode after abort");

        // R6 read-only mode
        ro_mode = 1'b1;
        prog(8'h80, 32'h11, 2'd0);
        check_status(8'h90, "R6 program refused");
        expect_word(8'h80, "R6 program not stored");
        bus_wr(8'h00, 32'h50, 2'd0);
        bus_wr(8'h80, 32'hE8, 2'd0);
        bus_wr(8'h80, 32'd0, 2'd2);
        bus_wr(8'h80, 32'hCAFECAFE, 2'd2);
        check_status(8'h90, "R6 block data refused");
        bus_wr(8'h00, 32'hD0, 2'd0);
        chk("R6 no commit in read-only", {31'h0, busy}, 32'h0);
        expect_word(8'h80, "R6 block data not stored");
        ro_mode = 1'b0;
        bus_wr(8'h00, 32'h50, 2'd0);

        // R3 exactly N+1 data writes (data low bytes equal the confirm code)
        bus_wr(8'hC0, 32'hE8, 2'd0);
        bus_wr(8'hC0, 32'd2, 2'd2);
        bus_wr(8'hC0, 32'h000000D0, 2'd2);
        bus_wr(8'hC4, 32'h000000D0, 2'd1);
        bus_wr(8'hC8, 32'h112233D0, 2'd3);
        chk("R3 no early commit", {31'h0, busy}, 32'h0);
        bus_wr(8'h00, 32'hD0, 2'd0);
        watch_commit("R3");
        mput(8'hC0, 32'h000000D0, 2'd2);
        mput(8'hC4, 32'h000000D0, 2'd1);
        mput(8'hC8, 32'h112233D0, 2'd2);
        expect_word(8'hC4, "R3 second data word");
        expect_word(8'hC8, "R2 width code 3 is four bytes");

        // R5 write ending exactly at block end, R11 command ignored while busy
        bus_wr(8'hA0, 32'hE8, 2'd0);
        bus_wr(8'hB3, 32'd0, 2'd2);
        bus_wr(8'hBC, 32'hCAFEF00D, 2'd2);
        check_status(8'h80, "R5 write ending at block end accepted");
        bus_wr(8'h00, 32'hD0, 2'd0);
        bus_wr(8'h00, 32'hE8, 2'd0);
        while (busy) @(negedge clk);
        mput(8'hBC, 32'hCAFEF00D, 2'd2);
        expect_word(8'hBC, "R5 last word of block committed");
        check_status(8'h80, "R11 status after busy write");
        prog(8'h10, 32'h77, 2'd0);
        expect_word(8'h10, "R11 write during busy ignored");

        finish_run();
    end

endmodule